// File: doc/BRIEF.md
# Selectable Static Branch Predictor

This block predicts the direction of each conditional branch as it enters fetch. It uses one of four fixed policies, picked by a two-bit select: never taken, always taken, backward-taken/forward-not-taken, or a compiler-set hint bit carried in the instruction. For every presented branch it returns a same-cycle direction and next fetch address. One cycle later it returns a registered tag holding the prediction, the branch address and the target, and that tag travels down the pipeline with the branch.

When the branch resolves, the pipeline hands the tag fields back together with the real outcome. A wrong guess raises a one-cycle flush with the corrected fetch address, and everything fetched on the guessed path is thrown away. While any predicted branch is still unresolved, a hold flag tells later stages that the work now in flight is speculative and must not commit to registers or memory. Two saturating counters record correct and incorrect resolutions.

Top module: `static_branch_predictor`

## Requirements
- R1: With policy select 2'b00 the prediction is not taken and the predicted next address is the branch address plus 4.
- R2: With policy select 2'b01 the prediction is taken and the predicted next address is the target.
- R3: With policy select 2'b10 the prediction is taken exactly when the target is less than or equal to the branch address (unsigned compare). The next address follows that choice.
- R4: With policy select 2'b11 the prediction equals the hint input.
- R5: The prediction is combinational in the request cycle. On the next clock edge the tag outputs capture the valid flag, the prediction, the branch address and the target. With no request, the tag valid output is low after the edge.
- R6: A resolve whose predicted bit differs from its actual bit raises flush for exactly the following cycle. The flush address is the target if the branch was actually taken, otherwise the branch address plus 4. A matching resolve raises no flush.
- R7: Each matching resolve increments the hit counter and each mismatching resolve increments the miss counter. Both saturate at all ones.
- R8: The hold output is high while the number of requested but unresolved branches is nonzero. That number rises on a request, falls on a resolve, is unchanged when both happen in the same cycle, and saturates at MAX_PEND.
- R9: A mispredicting resolve clears the unresolved count to zero on the same edge that raises flush, including any request made in that cycle.
- R10: After synchronous active-high reset, the tag outputs, flush, flush address, counters and hold are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 2 | Prediction policy: 00 never, 01 always, 10 backward-taken, 11 hint |
| br_valid | input | 1 | A branch is presented this cycle |
| br_pc | input | 32 | Branch instruction address |
| br_target | input | 32 | Branch target address |
| br_hint | input | 1 | Compiler hint bit from the instruction |
| pred_taken | output | 1 | Same-cycle predicted direction |
| pred_next_pc | output | 32 | Same-cycle predicted next fetch address |
| tag_valid | output | 1 | Registered tag is valid |
| tag_taken | output | 1 | Registered predicted direction |
| tag_pc | output | 32 | Registered branch address |
| tag_target | output | 32 | Registered target |
| spec_hold | output | 1 | At least one predicted branch is unresolved |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pred | input | 1 | Predicted direction returned from the tag |
| res_actual | input | 1 | Actual direction |
| res_pc | input | 32 | Branch address returned from the tag |
| res_target | input | 32 | Target returned from the tag |
| flush | output | 1 | One-cycle discard and redirect request |
| flush_pc | output | 32 | Corrected fetch address |
| hit_count | output | CNT_W | Saturating count of correct predictions |
| miss_count | output | CNT_W | Saturating count of mispredictions |

## Verification
Most of the state here is the unresolved-branch count and the two counters. An error in the count shows on the hold flag the cycle it should drop or rise, or stays hidden until the count drains. The bench therefore drives the count past its limit, drains it one branch at a time, and also empties it with a mispredict. A counter slip shows at the count port one edge after the resolve. Saturation is checked on a second instance with narrow counters. A wrong tag or flush address appears one edge after the request or resolve. Each of these is compared against the model on every clock.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int ADDR_W     = 32;
    localparam int INSN_BYTES = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        POL_NEVER  = 2'b00,
        POL_ALWAYS = 2'b01,
        POL_BACK   = 2'b10,
        POL_HINT   = 2'b11
    } policy_e;

    typedef struct packed {
        logic  valid;
        logic  taken;
        addr_t pc;
        addr_t target;
    } tag_t;

    typedef struct packed {
        logic  flush;
        addr_t redirect;
    } redirect_t;

    function automatic addr_t seq_addr(addr_t pc);
        return pc + addr_t'(INSN_BYTES);
    endfunction

    function automatic logic is_backward(addr_t pc, addr_t target);
        return target <= pc;
    endfunction

endpackage

// File: rtl/sbp_policy.sv
module sbp_policy
    import sbp_pkg::*;
(
    input  logic [1:0] policy_sel,
    input  addr_t      pc,
    input  addr_t      target,
    input  logic       hint,
    output logic       taken,
    output addr_t      next_pc
);
    policy_e pol;
    assign pol = policy_e'(policy_sel);

    always_comb begin
        unique case (pol)
            POL_NEVER:  taken = 1'b0;
            POL_ALWAYS: taken = 1'b1;
            POL_BACK:   taken = is_backward(pc, target);
            POL_HINT:   taken = hint;
            default:    taken = 1'b0;
        endcase
        next_pc = taken ? target : seq_addr(pc);
    end
endmodule

// File: rtl/sbp_resolve.sv
module sbp_resolve
    import sbp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      res_valid,
    input  logic      res_pred,
    input  logic      res_actual,
    input  addr_t     res_pc,
    input  addr_t     res_target,
    output logic      hit_evt,
    output logic      miss_evt,
    output redirect_t redir
);
    assign miss_evt = res_valid && (res_pred != res_actual);
    assign hit_evt  = res_valid && (res_pred == res_actual);

    always_ff @(posedge clk) begin
        if (rst) begin
            redir <= '0;
        end else begin
            redir.flush <= miss_evt;
            if (miss_evt)
                redir.redirect <= res_actual ? res_target : seq_addr(res_pc);
        end
    end

    p_flush_cause_r6: assert property (@(posedge clk) disable iff (rst)
        redir.flush |-> $past(res_valid && (res_pred != res_actual)));
    p_flush_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_actual && !res_pred) |=> redir.redirect == $past(res_target));
endmodule

// File: rtl/sbp_sat_counter.sv
module sbp_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> (count == $past(count) + 1'b1) && $past(inc));
    p_hold_top_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == TOP) |-> count == TOP);
endmodule

// File: rtl/sbp_pending.sv
module sbp_pending #(
    parameter int MAX_PEND = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic busy
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PEND);

    logic [PW-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst || clr)
            pend <= '0;
        else if (inc && !dec && pend != LIMIT)
            pend <= pend + 1'b1;
        else if (dec && !inc && pend != '0)
            pend <= pend - 1'b1;
    end

    assign busy = (pend != '0);

    p_drop_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(dec || clr));
    p_rise_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(inc));
endmodule

// File: rtl/static_branch_predictor.sv
module static_branch_predictor
    import sbp_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int MAX_PEND = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       policy_sel,
    input  logic             br_valid,
    input  logic [31:0]      br_pc,
    input  logic [31:0]      br_target,
    input  logic             br_hint,
    output logic             pred_taken,
    output logic [31:0]      pred_next_pc,
    output logic             tag_valid,
    output logic             tag_taken,
    output logic [31:0]      tag_pc,
    output logic [31:0]      tag_target,
    output logic             spec_hold,
    input  logic             res_valid,
    input  logic             res_pred,
    input  logic             res_actual,
    input  logic [31:0]      res_pc,
    input  logic [31:0]      res_target,
    output logic             flush,
    output logic [31:0]      flush_pc,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int NCNT = 2;

    tag_t      tag_q;
    redirect_t redir;
    logic      hit_evt, miss_evt;
    logic [NCNT-1:0]        cnt_inc;
    logic [NCNT*CNT_W-1:0]  cnt_bus;

    sbp_policy u_policy (
        .policy_sel (policy_sel),
        .pc         (br_pc),
        .target     (br_target),
        .hint       (br_hint),
        .taken      (pred_taken),
        .next_pc    (pred_next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.valid <= br_valid;
            if (br_valid) begin
                tag_q.taken  <= pred_taken;
                tag_q.pc     <= br_pc;
                tag_q.target <= br_target;
            end
        end
    end

    assign tag_valid  = tag_q.valid;
    assign tag_taken  = tag_q.taken;
    assign tag_pc     = tag_q.pc;
    assign tag_target = tag_q.target;

    sbp_resolve u_resolve (
        .clk        (clk),
        .rst        (rst),
        .res_valid  (res_valid),
        .res_pred   (res_pred),
        .res_actual (res_actual),
        .res_pc     (res_pc),
        .res_target (res_target),
        .hit_evt    (hit_evt),
        .miss_evt   (miss_evt),
        .redir      (redir)
    );

    assign flush    = redir.flush;
    assign flush_pc = redir.redirect;

    assign cnt_inc = {miss_evt, hit_evt};

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        sbp_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cnt_inc[i]),
            .count (cnt_bus[i*CNT_W +: CNT_W])
        );
    end

    assign hit_count  = cnt_bus[0 +: CNT_W];
    assign miss_count = cnt_bus[CNT_W +: CNT_W];

    sbp_pending #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .inc  (br_valid),
        .dec  (res_valid),
        .clr  (miss_evt),
        .busy (spec_hold)
    );

    p_never_r1: assert property (@(posedge clk) disable iff (rst)
        (policy_sel == 2'b00) |-> !pred_taken && pred_next_pc == br_pc + 32'd4);
    p_always_r2: assert property (@(posedge clk) disable iff (rst)
        (policy_sel == 2'b01) |-> pred_taken && pred_next_pc == br_target);
    p_back_r3: assert property (@(posedge clk) disable iff (rst)
        (policy_sel == 2'b10) |-> pred_taken == (br_target <= br_pc));
    p_hint_r4: assert property (@(posedge clk) disable iff (rst)
        (policy_sel == 2'b11) |-> pred_taken == br_hint);
    p_tag_follow_r5: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> tag_valid && tag_taken == $past(pred_taken) && tag_pc == $past(br_pc));
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flush |-> !spec_hold);
endmodule

// File: tb/static_branch_predictor_test.sv
module static_branch_predictor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  policy_sel = 2'b00;
    logic        br_valid = 1'b0, br_hint = 1'b0;
    logic [31:0] br_pc = '0, br_target = '0;
    logic        res_valid = 1'b0, res_pred = 1'b0, res_actual = 1'b0;
    logic [31:0] res_pc = '0, res_target = '0;

    logic        pred_taken, tag_valid, tag_taken, spec_hold, flush;
    logic [31:0] pred_next_pc, tag_pc, tag_target, flush_pc;
    logic [31:0] hit_count, miss_count;
    logic        s_pt, s_tv, s_tt, s_hold, s_fl;
    logic [31:0] s_np, s_tpc, s_ttg, s_fpc;
    logic [2:0]  s_hit, s_miss;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    longint e_tv, e_tt, e_tpc, e_ttg, e_fl, e_fpc, e_hit, e_miss, e_pend, s_hitm, s_missm, s_pend;

    always #4ns clk = ~clk;

    static_branch_predictor uut (
        .clk(clk), .rst(rst), .policy_sel(policy_sel), .br_valid(br_valid),
        .br_pc(br_pc), .br_target(br_target), .br_hint(br_hint),
        .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .tag_valid(tag_valid), .tag_taken(tag_taken), .tag_pc(tag_pc), .tag_target(tag_target),
        .spec_hold(spec_hold), .res_valid(res_valid), .res_pred(res_pred),
        .res_actual(res_actual), .res_pc(res_pc), .res_target(res_target),
        .flush(flush), .flush_pc(flush_pc), .hit_count(hit_count), .miss_count(miss_count));

    static_branch_predictor #(.CNT_W(3), .MAX_PEND(3)) uut_small (
        .clk(clk), .rst(rst), .policy_sel(policy_sel), .br_valid(br_valid),
        .br_pc(br_pc), .br_target(br_target), .br_hint(br_hint),
        .pred_taken(s_pt), .pred_next_pc(s_np),
        .tag_valid(s_tv), .tag_taken(s_tt), .tag_pc(s_tpc), .tag_target(s_ttg),
        .spec_hold(s_hold), .res_valid(res_valid), .res_pred(res_pred),
        .res_actual(res_actual), .res_pc(res_pc), .res_target(res_target),
        .flush(s_fl), .flush_pc(s_fpc), .hit_count(s_hit), .miss_count(s_miss));

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint mpred(logic [1:0] p, logic [31:0] pc, logic [31:0] tg, logic h);
        case (p)
            2'b00: return 0;
            2'b01: return 1;
            2'b10: return (tg <= pc) ? 1 : 0;
            default: return h ? 1 : 0;
        endcase
    endfunction

    task automatic model_reset();
        e_tv = 0; e_tt = 0; e_tpc = 0; e_ttg = 0; e_fl = 0; e_fpc = 0;
        e_hit = 0; e_miss = 0; e_pend = 0; s_hitm = 0; s_missm = 0; s_pend = 0;
    endtask

    task automatic check_regs();
        chk("R5 tag_valid", tag_valid, e_tv);
        if (e_tv != 0) begin
            chk("R5 tag_taken", tag_taken, e_tt);
            chk("R5 tag_pc", tag_pc, e_tpc);
            chk("R5 tag_target", tag_target, e_ttg);
        end
        chk("R6 flush", flush, e_fl);
        if (e_fl != 0) chk("R6 flush_pc", flush_pc, e_fpc);
        chk("R7 hit_count", hit_count, e_hit);
        chk("R7 miss_count", miss_count, e_miss);
        chk("R7 small hit_count", s_hit, s_hitm);
        chk("R7 small miss_count", s_miss, s_missm);
        chk("R8 spec_hold", spec_hold, e_pend != 0);
        chk("R8 small spec_hold", s_hold, s_pend != 0);
    endtask

    task automatic cyc(logic [1:0] p, logic v, logic [31:0] pc, logic [31:0] tg, logic h,
                       logic rv, logic rp, logic ra, logic [31:0] rpc, logic [31:0] rtg);
        longint pr, mis;
        policy_sel = p; br_valid = v; br_pc = pc; br_target = tg; br_hint = h;
        res_valid = rv; res_pred = rp; res_actual = ra; res_pc = rpc; res_target = rtg;
        #1ns;
        pr = mpred(p, pc, tg, h);
        chk(p == 2'b00 ? "R1 pred" : p == 2'b01 ? "R2 pred" : p == 2'b10 ? "R3 pred" : "R4 pred",
            pred_taken, pr);
        chk("R5 next_pc", pred_next_pc, pr != 0 ? longint'(tg) : longint'(pc + 32'd4));
        @(posedge clk);
        mis = (rv && rp != ra) ? 1 : 0;
        e_tv = v;
        if (v) begin e_tt = pr; e_tpc = pc; e_ttg = tg; end
        e_fl = mis;
        if (mis != 0) e_fpc = ra ? longint'(rtg) : longint'(rpc + 32'd4);
        if (rv && mis == 0) begin
            if (e_hit < 64'hFFFF_FFFF) e_hit++;
            if (s_hitm < 7) s_hitm++;
        end
        if (mis != 0) begin
            if (e_miss < 64'hFFFF_FFFF) e_miss++;
            if (s_missm < 7) s_missm++;
        end
        if (mis != 0) begin e_pend = 0; s_pend = 0; end // R9
        else if (v && !rv) begin
            if (e_pend < 15) e_pend++;
            if (s_pend < 3) s_pend++;
        end else if (rv && !v) begin
            if (e_pend > 0) e_pend--;
            if (s_pend > 0) s_pend--;
        end
        @(negedge clk);
        check_regs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_regs(); // R10 reset state
        // R1 never taken
        cyc(2'b00, 1, 32'h1000, 32'h0800, 1, 0, 0, 0, 0, 0);
        cyc(2'b00, 1, 32'h1000, 32'h2000, 0, 0, 0, 0, 0, 0);
        // R2 always taken
        cyc(2'b01, 1, 32'h2000, 32'h3000, 0, 0, 0, 0, 0, 0);
        cyc(2'b01, 0, 32'h2004, 32'h0010, 0, 0, 0, 0, 0, 0);
        // R3 backward, forward, equal
        cyc(2'b10, 1, 32'h4000, 32'h3ff0, 0, 0, 0, 0, 0, 0);
        cyc(2'b10, 1, 32'h4000, 32'h4010, 1, 0, 0, 0, 0, 0);
        cyc(2'b10, 1, 32'h4000, 32'h4000, 0, 0, 0, 0, 0, 0);
        cyc(2'b10, 1, 32'hFFFF_FFFC, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
        // R4 hint
        cyc(2'b11, 1, 32'h5000, 32'h6000, 1, 0, 0, 0, 0, 0);
        cyc(2'b11, 1, 32'h5000, 32'h4000, 0, 0, 0, 0, 0, 0);
        // R6/R7 resolves: correct, then simultaneous request + resolve
        cyc(2'b00, 0, 0, 0, 0, 1, 1, 1, 32'h2000, 32'h3000);
        cyc(2'b01, 1, 32'h7000, 32'h7100, 0, 1, 0, 0, 32'h1000, 32'h2000);
        // R6/R9 mispredict: predicted taken, actually not, with a request same cycle
        cyc(2'b01, 1, 32'h7100, 32'h7200, 0, 1, 1, 0, 32'h4000, 32'h3ff0);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // mispredict: predicted not taken, actually taken
        cyc(2'b00, 1, 32'h8000, 32'h9000, 0, 0, 0, 0, 0, 0);
        cyc(2'b00, 0, 0, 0, 0, 1, 0, 1, 32'h8000, 32'h9000);
        // back-to-back mispredicts
        cyc(2'b00, 1, 32'h8000, 32'h9000, 0, 1, 0, 1, 32'h8000, 32'h9000);
        cyc(2'b00, 0, 0, 0, 0, 1, 1, 0, 32'hA000, 32'hB000);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8 saturate unresolved count
        for (int i = 0; i < 20; i++)
            cyc(2'(i), 1, 32'h1_0000 + 32'(i*8), 32'h1_0000 + 32'(i*24) - 32'd64, 1'(i), 0, 0, 0, 0, 0);
        for (int i = 0; i < 17; i++)
            cyc(2'b00, 0, 0, 0, 0, 1, 0, 0, 32'(i*4), 32'(i*12));
        // R7 counter saturation on the narrow instance
        for (int i = 0; i < 10; i++)
            cyc(2'b11, 0, 0, 0, 0, 1, 1'(i), 1'(i), 32'h100, 32'h200);
        for (int i = 0; i < 10; i++)
            cyc(2'b10, 1'(i), 32'h300, 32'h200, 0, 1, 1'(i), 1'(~i), 32'h300 + 32'(i), 32'h500);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10 reset again mid-run
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_regs();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule